// File: doc/BRIEF.md
# I2C Bus Status Word Tracker

This block holds the second status word of a two-wire serial controller that also supports SMBus. It samples the raw clock and data lines through a synchronizer chain. From the synchronized lines it finds start, stop and repeated-start conditions on its own. It also takes single-cycle event strobes from the protocol engine: start generated, arbitration lost, address phase done with its read/write bit and match class, and address matched. From these it keeps the bus-busy, master, transmitter and address-type flags. It also returns the packet-error-check byte in the upper half of the word.

The word is a plain status output that is always valid, so it has no stream handshake. Two read strobes, one for each status word, carry the clear-on-ordered-read rule for the address-matched flag. A read of the first word arms the rule. A later read of the second word then clears the flag, including when the flag was set between the two reads.

Top module: `i2c_status_word`

## Requirements
- R1: After reset, `status_word` is 0 and `addr_hit_flag` is 0.
- R2: Bit 1 (busy) sets when the synchronized SCL or SDA is low and clears on a stop, which is an SDA rise while SCL is high. This tracking continues while `enable` is low. A pin change shows in the word SYNC_STAGES+1 clock edges later.
- R3: Bit 0 (master) sets on `ev_start_gen` while enabled. It clears on a stop, on `ev_arb_lost` or while `enable` is low, and a clear wins over a set in the same cycle.
- R4: Bit 2 (transmitter) loads `addr_rw` on `ev_addr_done` while enabled. It clears on a stop, on a repeated start (an SDA fall while SCL is high with busy already set), on `ev_arb_lost` or while `enable` is low.
- R5: On `ev_addr_done`, the bits 7:4 are loaded from `addr_class` (0 primary, 1 secondary, 2 general call, 3 device default, 4 host). Bit 7 is 1 only for class 1. Bit 4 is 1 for class 2 only when `gcall_en` is high. Bit 5 is 1 for class 3 only when `arp_en` is high. Bit 6 is 1 for class 4 only when both `host_type_en` and `arp_en` are high.
- R6: Bits 7:4 clear on a stop, on a repeated start, or while `enable` is low.
- R7: Bits 15:8 equal `crc_byte` when `crc_chk_en` is high and are 0 otherwise. Bit 3 is always 0.
- R8: `addr_hit_flag` sets one edge after `ev_addr_hit` while enabled. A pulse on `rd_first` arms the clear, and a later `rd_second` clears the flag and disarms. A `rd_second` without an earlier `rd_first` leaves the flag as it is.
- R9: While `enable` is low, `ev_start_gen`, `ev_addr_done` and `ev_addr_hit` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable |
| scl_pin | input | 1 | Raw SCL line level |
| sda_pin | input | 1 | Raw SDA line level |
| crc_chk_en | input | 1 | Packet error checking enabled |
| crc_byte | input | CRC_W | Internally computed check byte |
| gcall_en | input | 1 | General call answering enabled |
| arp_en | input | 1 | Address resolution enabled |
| host_type_en | input | 1 | Host-type SMBus operation |
| ev_start_gen | input | 1 | Start generated, master mode entered |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_addr_done | input | 1 | Whole address phase finished |
| addr_rw | input | 1 | R/W bit of the address byte |
| addr_class | input | 3 | Which address matched |
| ev_addr_hit | input | 1 | Address-matched event |
| rd_first | input | 1 | First status word read strobe |
| rd_second | input | 1 | Second status word read strobe |
| status_word | output | CRC_W+8 | Status word |
| addr_hit_flag | output | 1 | Address-matched flag |

## Verification
The bench builds the block with SYNC_STAGES=3 instead of the default 2. This checks that every line-driven flag follows the parameterized latency and not a fixed delay. The default CRC_W of 8 is kept, so the full check byte passes through. The directed cases cover busy tracking while disabled, stops, repeated starts after busy, the gating of each address class, and the ordered-read clear race. A seeded random phase mixes event strobes, enables and read pairs against a reference model.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;
  typedef enum logic [2:0] {
    MC_PRIMARY = 3'd0,
    MC_SECOND  = 3'd1,
    MC_GCALL   = 3'd2,
    MC_DEVDEF  = 3'd3,
    MC_HOST    = 3'd4
  } match_class_e;

  typedef struct packed {
    logic second_hit;
    logic host_hit;
    logic devdef_hit;
    logic gcall_hit;
  } match_bits_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic rstart;
  } bus_cond_t;
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '1;
        else if (g == 0) chain[g] <= raw_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect
  import i2c_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_s,
  input  logic      sda_s,
  output bus_cond_t cond,
  output logic      busy
);
  logic scl_p, sda_p;
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    cond.stop   = sda_s & ~sda_p & scl_s & scl_p;
    cond.start  = ~sda_s & sda_p & scl_s & scl_p;
    cond.rstart = cond.start & busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (cond.stop) busy_q <= 1'b0;
    else if (!scl_s || !sda_s) busy_q <= 1'b1;
  end

  assign busy = busy_q;
endmodule

// File: rtl/role_flags.sv
module role_flags
  import i2c_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  bus_cond_t cond,
  input  logic      ev_start_gen,
  input  logic      ev_arb_lost,
  input  logic      ev_addr_done,
  input  logic      addr_rw,
  output logic      master,
  output logic      xmit
);
  logic master_q, xmit_q;
  logic master_clr, xmit_clr;

  always_comb begin
    master_clr = !enable || cond.stop || ev_arb_lost;
    xmit_clr   = !enable || cond.stop || cond.rstart || ev_arb_lost;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      xmit_q   <= 1'b0;
    end else begin
      if (master_clr) master_q <= 1'b0;
      else if (ev_start_gen) master_q <= 1'b1;

      if (xmit_clr) xmit_q <= 1'b0;
      else if (ev_addr_done) xmit_q <= addr_rw;
    end
  end

  assign master = master_q;
  assign xmit   = xmit_q;
endmodule

// File: rtl/match_flags.sv
module match_flags
  import i2c_status_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  bus_cond_t   cond,
  input  logic        ev_addr_done,
  input  logic [2:0]  addr_class,
  input  logic        gcall_en,
  input  logic        arp_en,
  input  logic        host_type_en,
  output match_bits_t bits
);
  match_bits_t bits_q, bits_d;
  match_class_e cls;

  always_comb begin
    cls = match_class_e'(addr_class);
    bits_d.second_hit = (cls == MC_SECOND);
    bits_d.gcall_hit  = (cls == MC_GCALL) && gcall_en;
    bits_d.devdef_hit = (cls == MC_DEVDEF) && arp_en;
    bits_d.host_hit   = (cls == MC_HOST) && arp_en && host_type_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else if (!enable || cond.stop || cond.rstart) bits_q <= '0;
    else if (ev_addr_done) bits_q <= bits_d;
  end

  assign bits = bits_q;
endmodule

// File: rtl/addr_read_seq.sv
module addr_read_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ev_addr_hit,
  input  logic rd_first,
  input  logic rd_second,
  output logic hit_flag
);
  logic armed_q, hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      if (rd_first) armed_q <= 1'b1;
      else if (rd_second) armed_q <= 1'b0;

      if (rd_second && armed_q) hit_q <= 1'b0;
      else if (ev_addr_hit && enable) hit_q <= 1'b1;
    end
  end

  assign hit_flag = hit_q;
endmodule

// File: rtl/i2c_status_word.sv
module i2c_status_word
  import i2c_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CRC_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               scl_pin,
  input  logic               sda_pin,
  input  logic               crc_chk_en,
  input  logic [CRC_W-1:0]   crc_byte,
  input  logic               gcall_en,
  input  logic               arp_en,
  input  logic               host_type_en,
  input  logic               ev_start_gen,
  input  logic               ev_arb_lost,
  input  logic               ev_addr_done,
  input  logic               addr_rw,
  input  logic [2:0]         addr_class,
  input  logic               ev_addr_hit,
  input  logic               rd_first,
  input  logic               rd_second,
  output logic [CRC_W+7:0]   status_word,
  output logic               addr_hit_flag
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_s;
  bus_cond_t        cond;
  logic             busy, master, xmit;
  match_bits_t      mbits;
  logic             stop_det;

  bus_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in({scl_pin, sda_pin}), .sync_out(lines_s)
  );

  bus_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .cond(cond), .busy(busy)
  );

  role_flags u_role (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cond(cond),
    .ev_start_gen(ev_start_gen), .ev_arb_lost(ev_arb_lost),
    .ev_addr_done(ev_addr_done), .addr_rw(addr_rw),
    .master(master), .xmit(xmit)
  );

  match_flags u_match (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cond(cond),
    .ev_addr_done(ev_addr_done), .addr_class(addr_class),
    .gcall_en(gcall_en), .arp_en(arp_en), .host_type_en(host_type_en),
    .bits(mbits)
  );

  addr_read_seq u_rdseq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ev_addr_hit(ev_addr_hit),
    .rd_first(rd_first), .rd_second(rd_second), .hit_flag(addr_hit_flag)
  );

  assign stop_det = cond.stop;

  always_comb begin
    status_word = '0;
    status_word[CRC_W+7:8] = crc_chk_en ? crc_byte : '0;
    status_word[7] = mbits.second_hit;
    status_word[6] = mbits.host_hit;
    status_word[5] = mbits.devdef_hit;
    status_word[4] = mbits.gcall_hit;
    status_word[2] = xmit;
    status_word[1] = busy;
    status_word[0] = master;
  end
endmodule

// File: rtl/i2c_status_checker.sv
module i2c_status_checker #(
  parameter int CRC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             gcall_en,
  input logic             ev_arb_lost,
  input logic             rd_first,
  input logic             rd_second,
  input logic             stop_det,
  input logic [CRC_W+7:0] status_word,
  input logic             addr_hit_flag
);
  logic chk_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_armed <= 1'b0;
    else if (rd_first) chk_armed <= 1'b1;
    else if (rd_second) chk_armed <= 1'b0;
  end

  a_r2_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !status_word[1]);

  a_r3_disable_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !status_word[0]);

  a_r4_arb_clears_xmit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> !status_word[2]);

  a_r5_gcall_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[4]) |-> $past(gcall_en && enable));

  a_r6_stop_clears_match: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (status_word[7:4] == 4'b0000));

  a_r8_ordered_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && rd_second && !rd_first) |=> !addr_hit_flag);

  a_r9_master_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[0]) |-> $past(enable));
endmodule

bind i2c_status_word i2c_status_checker #(.CRC_W(CRC_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .enable(enable), .gcall_en(gcall_en),
  .ev_arb_lost(ev_arb_lost), .rd_first(rd_first), .rd_second(rd_second),
  .stop_det(stop_det), .status_word(status_word), .addr_hit_flag(addr_hit_flag)
);

// File: tb/test_i2c_status_word.sv
`timescale 1ns/1ps
module test_i2c_status_word;
  localparam int SYNC = 3;
  localparam int CW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, scl_pin = 1'b1, sda_pin = 1'b1;
  logic crc_chk_en = 1'b0;
  logic [CW-1:0] crc_byte = '0;
  logic gcall_en = 1'b0, arp_en = 1'b0, host_type_en = 1'b0;
  logic ev_start_gen = 1'b0, ev_arb_lost = 1'b0, ev_addr_done = 1'b0, addr_rw = 1'b0;
  logic [2:0] addr_class = 3'd0;
  logic ev_addr_hit = 1'b0, rd_first = 1'b0, rd_second = 1'b0;
  logic [CW+7:0] status_word;
  logic addr_hit_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_status_word #(.SYNC_STAGES(SYNC), .CRC_W(CW)) i_i2c_status_word (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_pin(scl_pin), .sda_pin(sda_pin),
    .crc_chk_en(crc_chk_en), .crc_byte(crc_byte), .gcall_en(gcall_en), .arp_en(arp_en),
    .host_type_en(host_type_en), .ev_start_gen(ev_start_gen), .ev_arb_lost(ev_arb_lost),
    .ev_addr_done(ev_addr_done), .addr_rw(addr_rw), .addr_class(addr_class),
    .ev_addr_hit(ev_addr_hit), .rd_first(rd_first), .rd_second(rd_second),
    .status_word(status_word), .addr_hit_flag(addr_hit_flag)
  );

  // reference model state for the random phase
  logic m_mst, m_tx, m_busy, m_hit, m_arm;
  logic [3:0] m_match;

  function automatic logic [3:0] exp_match(logic [2:0] c, logic gc, logic arp, logic host);
    exp_match = {c == 3'd1, (c == 3'd4) && arp && host, (c == 3'd3) && arp, (c == 3'd2) && gc};
  endfunction

  function automatic logic [CW+7:0] exp_word(logic crcen, logic [CW-1:0] crc);
    exp_word = {crcen ? crc : {CW{1'b0}}, m_match, 1'b0, m_tx, m_busy, m_mst};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic lines(logic scl, logic sda);
    scl_pin = scl;
    sda_pin = sda;
    cyc(SYNC + 2);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    cyc(1);
    sig = 1'b0;
  endtask

  // full stop sequence from any state: SCL low, SDA low, SCL high, SDA high
  task automatic bus_stop();
    lines(1'b0, sda_pin);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 word at reset", 32'(status_word), 32'h0);
    chk("R1 hit at reset", 32'(addr_hit_flag), 32'h0);
    rst_n = 1'b1;
    cyc(2);
    enable = 1'b1;

    // R2 busy with line latency
    sda_pin = 1'b0;
    cyc(SYNC);
    chk("R2 busy not yet", 32'(status_word[1]), 32'h0);
    cyc(1);
    chk("R2 busy after latency", 32'(status_word[1]), 32'h1);
    cyc(1);
    bus_stop();
    chk("R2 busy cleared by stop", 32'(status_word[1]), 32'h0);

    // R2 tracking while disabled
    enable = 1'b0;
    lines(1'b0, 1'b1);
    chk("R2 busy while disabled", 32'(status_word[1]), 32'h1);
    bus_stop();
    chk("R2 stop while disabled", 32'(status_word[1]), 32'h0);
    enable = 1'b1;
    cyc(1);

    // R3 master set and clears
    pulse(ev_start_gen);
    chk("R3 master set", 32'(status_word[0]), 32'h1);
    lines(1'b1, 1'b0);
    bus_stop();
    chk("R3 master cleared by stop", 32'(status_word[0]), 32'h0);
    pulse(ev_start_gen);
    pulse(ev_arb_lost);
    chk("R3 master cleared by arb loss", 32'(status_word[0]), 32'h0);
    pulse(ev_start_gen);
    enable = 1'b0;
    cyc(1);
    chk("R3 master cleared by disable", 32'(status_word[0]), 32'h0);
    enable = 1'b1;
    ev_start_gen = 1'b1; ev_arb_lost = 1'b1;
    cyc(1);
    ev_start_gen = 1'b0; ev_arb_lost = 1'b0;
    chk("R3 clear wins over set", 32'(status_word[0]), 32'h0);

    // R4/R6 repeated start clears transmitter and match bits
    lines(1'b1, 1'b0);
    addr_rw = 1'b1; addr_class = 3'd1;
    pulse(ev_addr_done);
    chk("R4 transmitter loads rw", 32'(status_word[2]), 32'h1);
    chk("R5 secondary match bit", 32'(status_word[7:4]), 32'h8);
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);
    chk("R4 repeated start clears transmitter", 32'(status_word[2]), 32'h0);
    chk("R6 repeated start clears match", 32'(status_word[7:4]), 32'h0);
    chk("R2 busy kept across repeated start", 32'(status_word[1]), 32'h1);
    addr_class = 3'd2; gcall_en = 1'b1;
    pulse(ev_addr_done);
    chk("R5 general call enabled", 32'(status_word[7:4]), 32'h1);
    bus_stop();
    chk("R6 stop clears match", 32'(status_word[7:4]), 32'h0);
    chk("R4 stop clears transmitter", 32'(status_word[2]), 32'h0);

    // R5 gating
    gcall_en = 1'b0;
    pulse(ev_addr_done);
    chk("R5 general call gated off", 32'(status_word[7:4]), 32'h0);
    addr_class = 3'd4; arp_en = 1'b1; host_type_en = 1'b0;
    pulse(ev_addr_done);
    chk("R5 host needs host type", 32'(status_word[7:4]), 32'h0);
    host_type_en = 1'b1;
    pulse(ev_addr_done);
    chk("R5 host both enabled", 32'(status_word[7:4]), 32'h4);
    addr_class = 3'd3;
    pulse(ev_addr_done);
    chk("R5 device default", 32'(status_word[7:4]), 32'h2);
    enable = 1'b0;
    cyc(1);
    chk("R6 disable clears match", 32'(status_word[7:4]), 32'h0);

    // R9 strobes ignored while disabled
    addr_rw = 1'b1;
    ev_start_gen = 1'b1; ev_addr_done = 1'b1; ev_addr_hit = 1'b1;
    cyc(1);
    ev_start_gen = 1'b0; ev_addr_done = 1'b0; ev_addr_hit = 1'b0;
    chk("R9 word unchanged while disabled", 32'(status_word[7:0]), 32'h0);
    chk("R9 hit unchanged while disabled", 32'(addr_hit_flag), 32'h0);
    enable = 1'b1;

    // R7 check byte and reserved bit
    crc_byte = 8'hA5; crc_chk_en = 1'b1;
    #1;
    chk("R7 check byte shown", 32'(status_word[15:8]), 32'hA5);
    crc_chk_en = 1'b0;
    #1;
    chk("R7 check byte hidden", 32'(status_word[15:8]), 32'h0);
    chk("R7 reserved bit", 32'(status_word[3]), 32'h0);
    cyc(1);

    // R8 ordered read
    pulse(ev_addr_hit);
    chk("R8 hit set", 32'(addr_hit_flag), 32'h1);
    pulse(rd_second);
    chk("R8 lone second read keeps flag", 32'(addr_hit_flag), 32'h1);
    pulse(rd_first);
    cyc(2);
    pulse(rd_second);
    chk("R8 ordered read clears", 32'(addr_hit_flag), 32'h0);
    pulse(rd_first);
    pulse(ev_addr_hit);
    chk("R8 set after first read", 32'(addr_hit_flag), 32'h1);
    pulse(rd_second);
    chk("R8 late set still cleared", 32'(addr_hit_flag), 32'h0);
    pulse(ev_addr_hit);
    pulse(rd_second);
    chk("R8 second read disarms", 32'(addr_hit_flag), 32'h1);
    pulse(rd_first);
    pulse(rd_second);

    // random phase, lines idle high
    void'($urandom(32'd1234));
    m_mst = status_word[0]; m_tx = status_word[2]; m_busy = status_word[1];
    m_match = status_word[7:4]; m_hit = addr_hit_flag; m_arm = 1'b0;
    chk("R2 idle before random", 32'(m_busy), 32'h0);
    for (int n = 0; n < 3000; n++) begin
      logic ro, rs;
      enable       = ($urandom_range(0, 9) != 0);
      ev_start_gen = ($urandom_range(0, 3) == 0);
      ev_arb_lost  = ($urandom_range(0, 7) == 0);
      ev_addr_done = ($urandom_range(0, 3) == 0);
      addr_rw      = 1'($urandom);
      addr_class   = 3'($urandom_range(0, 5));
      gcall_en     = 1'($urandom);
      arp_en       = 1'($urandom);
      host_type_en = 1'($urandom);
      ev_addr_hit  = ($urandom_range(0, 4) == 0);
      ro = ($urandom_range(0, 5) == 0);
      rs = !ro && ($urandom_range(0, 4) == 0);
      rd_first = ro; rd_second = rs;
      crc_chk_en = 1'($urandom);
      crc_byte = 8'($urandom);
      // model update
      if (!enable) begin
        m_mst = 1'b0; m_tx = 1'b0; m_match = 4'h0;
      end else begin
        if (ev_arb_lost) begin
          m_mst = 1'b0; m_tx = 1'b0;
        end else begin
          if (ev_start_gen) m_mst = 1'b1;
          if (ev_addr_done) m_tx = addr_rw;
        end
        if (ev_addr_done) m_match = exp_match(addr_class, gcall_en, arp_en, host_type_en);
      end
      if (rs && m_arm) m_hit = 1'b0;
      else if (ev_addr_hit && enable) m_hit = 1'b1;
      if (ro) m_arm = 1'b1;
      else if (rs) m_arm = 1'b0;
      cyc(1);
      chk("R3/R4/R5/R7 random word", 32'(status_word), 32'(exp_word(crc_chk_en, crc_byte)));
      chk("R8 random hit flag", 32'(addr_hit_flag), 32'(m_hit));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule